// File: doc/BRIEF.md
# Banked Memory-Management Unit with Block Extension

This block translates a 16-bit CPU address into a 23-bit physical RAM address. The CPU space is cut into eight 8 KB windows, and the physical space into 1024 blocks of 8 KB, for a total of 8 MB. Sixteen mapping registers hold a 10-bit physical block number each. They form two task maps of eight registers, and a task-select input picks which map is active. Logical address bits 15–13 pick the register inside that map. The low 13 address bits pass through unchanged. When the mapping enable is low, the block falls back to a fixed mapping onto the top 64 KB of the 512 KB base region.

An extension register supplies the top bits of both the CPU and the video addresses. Its two CPU bank bits act only at the moment a mapping register is written: they are captured into that register together with the eight written data bits. Changing the extension register later does not disturb any mapping that already exists. Its four video bits act at once. They form the top of a 20-bit video start offset, and the lower 16 bits come from two offset byte registers. The offset counts in 8-byte steps.

All of the registers are written through one port with an address, a byte of data and a strobe. None of them can be read back. The design has no sequencing state. Every register write completes at the next rising clock edge, and translation is purely combinational.

Top module: `bank_mmu`

## Requirements
- R1: After reset, the mapping register at write address 0xFFA0+n holds block number 0x38 + (n mod 8), the video offset is 0, and the CPU bank bits are 0.
- R2: A strobed write to 0xFFA0+n (n = 0..15) stores a 10-bit block number into register n. Bits 7–0 come from the write data and bits 9–8 are the CPU bank bits held at the time of the write. The new value is visible from the next clock edge.
- R3: Writing the extension register (0xFF9B) does not change any stored mapping. Only later mapping-register writes pick up its new bank bits.
- R4: When mapping is enabled, the selected register is number {task_sel, cpu_addr[15:13]}. Task 0 uses registers 0xFFA0–0xFFA7 and task 1 uses 0xFFA8–0xFFAF.
- R5: phys_addr[12:0] always equals cpu_addr[12:0], and phys_addr[22:13] is the selected 10-bit block number.
- R6: When mmu_en is low, phys_addr is {0x38 + cpu_addr[15:13], cpu_addr[12:0]} with the block number zero-extended to 10 bits, whatever the mapping registers hold.
- R7: vid_offset is {ext[3:0], byte at 0xFF9D, byte at 0xFF9E}. It is updated by the next clock edge after any of these three writes.
- R8: In the extension register, bits 3–0 are the video bits, bits 5–4 are the CPU bank bits (bit 5 becomes block bit 9), and bits 7–6 are discarded.
- R9: A write with wr_en low, or a write to any address outside the map range and the three control addresses, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Register write address |
| wr_data | input | 8 | Register write data |
| cpu_addr | input | 16 | Logical CPU address |
| task_sel | input | 1 | Active task map |
| mmu_en | input | 1 | Mapping enable (low = fixed fallback map) |
| phys_addr | output | 23 | Physical byte address |
| vid_offset | output | 20 | Video start offset in 8-byte units |

## Verification
On every cycle, the assertions check the following. The low 13 address bits pass straight through. The disabled-mode fallback map holds. A byte written to a mapping register appears in the lower block bits whenever that register is selected. The video offset stays still unless one of its three addresses was written, and a write to the low offset byte lands at once. Some behaviour can only be shown by the bench's scenarios: the reset identity map, the delayed capture of the bank bits, the fact that later extension writes leave earlier mappings alone, the dropped bits 7–6, and the choice between the two task maps. The bench uses a reference model for these.

// File: rtl/bmmu_pkg.sv
package bmmu_pkg;
    // Decoded register-write request
    typedef struct packed {
        logic map_we;
        logic [3:0] map_idx;
        logic ext_we;
        logic vhi_we;
        logic vlo_we;
    } bmmu_wr_t;

    // Reset block number of mapping register n: fixed base plus window
    function automatic int unsigned bmmu_rst_block(input int unsigned base,
                                                   input int unsigned n,
                                                   input int unsigned slots);
        return base + (n % slots);
    endfunction
endpackage

// File: rtl/bmmu_wr_decode.sv
module bmmu_wr_decode #(
    parameter int CPU_AW = 16,
    parameter int IDX_W = 4,
    parameter logic [15:0] MAP_BASE = 16'hFFA0,
    parameter logic [15:0] EXT_ADDR = 16'hFF9B,
    parameter logic [15:0] VHI_ADDR = 16'hFF9D,
    parameter logic [15:0] VLO_ADDR = 16'hFF9E
) (
    input  logic              wr_en,
    input  logic [CPU_AW-1:0] wr_addr,
    output bmmu_pkg::bmmu_wr_t wr_req
);
    logic map_hit;

    always_comb begin
        map_hit = (wr_addr[CPU_AW-1:IDX_W] == MAP_BASE[CPU_AW-1:IDX_W]);
        wr_req.map_we = wr_en && map_hit;
        wr_req.map_idx = wr_addr[IDX_W-1:0];
        wr_req.ext_we = wr_en && (wr_addr == EXT_ADDR);
        wr_req.vhi_we = wr_en && (wr_addr == VHI_ADDR);
        wr_req.vlo_we = wr_en && (wr_addr == VLO_ADDR);
    end
endmodule

// File: rtl/bmmu_ctrl_regs.sv
module bmmu_ctrl_regs #(
    parameter int VEXT_W = 4,
    parameter int BANK_W = 2,
    parameter int BYTE_W = 8,
    localparam int EXT_W = VEXT_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_we,
    input  logic              vhi_we,
    input  logic              vlo_we,
    input  logic [EXT_W-1:0]  ext_d,
    input  logic [BYTE_W-1:0] byte_d,
    output logic [BANK_W-1:0] cpu_bank,
    output logic [VEXT_W+2*BYTE_W-1:0] vid_offset
);
    logic [EXT_W-1:0]  ext_q;
    logic [BYTE_W-1:0] vhi_q;
    logic [BYTE_W-1:0] vlo_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q <= '0;
            vhi_q <= '0;
            vlo_q <= '0;
        end else begin
            if (ext_we) ext_q <= ext_d;
            if (vhi_we) vhi_q <= byte_d;
            if (vlo_we) vlo_q <= byte_d;
        end
    end

    always_comb begin
        cpu_bank = ext_q[EXT_W-1:VEXT_W];
        vid_offset = {ext_q[VEXT_W-1:0], vhi_q, vlo_q};
    end
endmodule

// File: rtl/bmmu_map_file.sv
module bmmu_map_file #(
    parameter int NREG = 16,
    parameter int SLOTS = 8,
    parameter int BLK_W = 10,
    parameter int BYTE_W = 8,
    parameter int DEF_BASE = 'h38,
    localparam int IDX_W = $clog2(NREG),
    localparam int BANK_W = BLK_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] data,
    input  logic [BANK_W-1:0] bank,
    output logic [NREG-1:0][BLK_W-1:0] blocks
);
    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        localparam logic [BLK_W-1:0] RST_BLK =
            BLK_W'(bmmu_pkg::bmmu_rst_block(DEF_BASE, gi, SLOTS));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                blocks[gi] <= RST_BLK;
            end else if (we && (idx == IDX_W'(gi))) begin
                // bank bits are captured only here, at the write
                blocks[gi] <= {bank, data};
            end
        end
    end
endmodule

// File: rtl/bmmu_translate.sv
module bmmu_translate #(
    parameter int CPU_AW = 16,
    parameter int PAGE_W = 13,
    parameter int BLK_W = 10,
    parameter int TASK_W = 1,
    parameter int DEF_BASE = 'h38,
    localparam int SLOT_W = CPU_AW - PAGE_W,
    localparam int NREG = (1 << (SLOT_W + TASK_W))
) (
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [TASK_W-1:0] task_sel,
    input  logic              mmu_en,
    input  logic [NREG-1:0][BLK_W-1:0] blocks,
    output logic [BLK_W+PAGE_W-1:0] phys_addr
);
    logic [SLOT_W-1:0] slot;
    logic [BLK_W-1:0]  blk;

    always_comb begin
        slot = cpu_addr[CPU_AW-1:PAGE_W];
        if (mmu_en) blk = blocks[{task_sel, slot}];
        else        blk = BLK_W'(DEF_BASE) + BLK_W'(slot);
        phys_addr = {blk, cpu_addr[PAGE_W-1:0]};
    end
endmodule

// File: rtl/bank_mmu.sv
module bank_mmu #(
    parameter int CPU_AW = 16,
    parameter int PAGE_W = 13,
    parameter int BYTE_W = 8,
    parameter int BANK_W = 2,
    parameter int VEXT_W = 4,
    parameter int TASK_W = 1,
    parameter int DEF_BASE = 'h38,
    parameter logic [15:0] MAP_BASE = 16'hFFA0,
    parameter logic [15:0] EXT_ADDR = 16'hFF9B,
    parameter logic [15:0] VHI_ADDR = 16'hFF9D,
    parameter logic [15:0] VLO_ADDR = 16'hFF9E,
    localparam int BLK_W = BYTE_W + BANK_W,
    localparam int PHYS_W = BLK_W + PAGE_W,
    localparam int SLOTS = 1 << (CPU_AW - PAGE_W),
    localparam int NREG = SLOTS << TASK_W,
    localparam int IDX_W = $clog2(NREG),
    localparam int VOFF_W = VEXT_W + 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CPU_AW-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [TASK_W-1:0] task_sel,
    input  logic              mmu_en,
    output logic [PHYS_W-1:0] phys_addr,
    output logic [VOFF_W-1:0] vid_offset
);
    bmmu_pkg::bmmu_wr_t wr_req;
    logic [BANK_W-1:0]  cpu_bank;
    logic [NREG-1:0][BLK_W-1:0] blocks;

    bmmu_wr_decode #(
        .CPU_AW(CPU_AW), .IDX_W(IDX_W), .MAP_BASE(MAP_BASE),
        .EXT_ADDR(EXT_ADDR), .VHI_ADDR(VHI_ADDR), .VLO_ADDR(VLO_ADDR)
    ) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_req(wr_req)
    );

    bmmu_ctrl_regs #(
        .VEXT_W(VEXT_W), .BANK_W(BANK_W), .BYTE_W(BYTE_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ext_we(wr_req.ext_we), .vhi_we(wr_req.vhi_we), .vlo_we(wr_req.vlo_we),
        .ext_d(wr_data[VEXT_W+BANK_W-1:0]), .byte_d(wr_data),
        .cpu_bank(cpu_bank), .vid_offset(vid_offset)
    );

    bmmu_map_file #(
        .NREG(NREG), .SLOTS(SLOTS), .BLK_W(BLK_W), .BYTE_W(BYTE_W),
        .DEF_BASE(DEF_BASE)
    ) u_maps (
        .clk(clk), .rst_n(rst_n),
        .we(wr_req.map_we), .idx(wr_req.map_idx[IDX_W-1:0]),
        .data(wr_data), .bank(cpu_bank), .blocks(blocks)
    );

    bmmu_translate #(
        .CPU_AW(CPU_AW), .PAGE_W(PAGE_W), .BLK_W(BLK_W),
        .TASK_W(TASK_W), .DEF_BASE(DEF_BASE)
    ) u_xlat (
        .cpu_addr(cpu_addr), .task_sel(task_sel), .mmu_en(mmu_en),
        .blocks(blocks), .phys_addr(phys_addr)
    );
endmodule

// File: rtl/bank_mmu_checks.sv
module bank_mmu_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [15:0] wr_addr,
    input logic [7:0]  wr_data,
    input logic [15:0] cpu_addr,
    input logic [0:0]  task_sel,
    input logic        mmu_en,
    input logic [22:0] phys_addr,
    input logic [19:0] vid_offset
);
    // R5
    offset_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[12:0] == cpu_addr[12:0]);

    // R6
    fallback_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mmu_en |-> phys_addr[22:13] == 10'(7'h38 + {4'b0, cpu_addr[15:13]}));

    // R2
    map_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[15:4] == 12'hFFA) |=>
        (!(mmu_en && task_sel[0] == $past(wr_addr[3])
           && cpu_addr[15:13] == $past(wr_addr[2:0]))
         || phys_addr[20:13] == $past(wr_data)));

    // R7
    vid_low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 16'hFF9E) |=> vid_offset[7:0] == $past(wr_data));

    // R9
    vid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_addr == 16'hFF9B || wr_addr == 16'hFF9D
                    || wr_addr == 16'hFF9E)) |=> $stable(vid_offset));
endmodule

bind bank_mmu bank_mmu_checks u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cpu_addr(cpu_addr), .task_sel(task_sel),
    .mmu_en(mmu_en), .phys_addr(phys_addr), .vid_offset(vid_offset)
);

// File: tb/bank_mmu_test.sv
module bank_mmu_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] cpu_addr = '0;
    logic [0:0]  task_sel = '0;
    logic        mmu_en = 1'b1;
    logic [22:0] phys_addr;
    logic [19:0] vid_offset;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    logic [9:0] m_map [16];
    logic [5:0] m_ext;
    logic [7:0] m_vhi, m_vlo;

    bank_mmu uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cpu_addr(cpu_addr), .task_sel(task_sel),
        .mmu_en(mmu_en), .phys_addr(phys_addr), .vid_offset(vid_offset)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [22:0] exp_phys(input logic [15:0] a,
                                             input logic t, input logic en);
        logic [9:0] b;
        if (en) b = m_map[{t, a[15:13]}];
        else    b = 10'h38 + 10'(a[15:13]);
        return {b, a[12:0]};
    endfunction

    function automatic logic [19:0] exp_vid();
        return {m_ext[3:0], m_vhi, m_vlo};
    endfunction

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_map[i] = 10'h38 + 10'(i % 8);
        m_ext = '0; m_vhi = '0; m_vlo = '0;
    endtask

    task automatic wr(input logic en, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        if (en) begin
            if (a[15:4] == 12'hFFA) m_map[a[3:0]] = {m_ext[5:4], d};
            else if (a == 16'hFF9B) m_ext = d[5:0];
            else if (a == 16'hFF9D) m_vhi = d;
            else if (a == 16'hFF9E) m_vlo = d;
        end
    endtask

    task automatic look(input string req, input logic [15:0] a,
                        input logic t, input logic en);
        @(negedge clk);
        cpu_addr = a; task_sel = t; mmu_en = en;
        #1;
        chk(req, 32'(phys_addr), 32'(exp_phys(a, t, en)));
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: identity reset map, video offset clear
        for (int i = 0; i < 16; i++)
            look("R1", {3'(i % 8), 13'h0ABC}, 1'(i / 8), 1'b1);
        chk("R1 vid", 32'(vid_offset), 32'h0);

        // R2 R8: bank bits 11 captured at map write
        wr(1'b1, 16'hFF9B, 8'h30);
        wr(1'b1, 16'hFFA2, 8'h5A);
        look("R2", 16'h4123, 1'b0, 1'b1);
        chk("R8 bank", 32'(phys_addr[22:21]), 32'h3);
        // R3: clearing bank bits leaves existing mapping
        wr(1'b1, 16'hFF9B, 8'h00);
        look("R3", 16'h5FFF, 1'b0, 1'b1);
        chk("R3 kept", 32'(phys_addr[22:13]), 32'h35A);
        wr(1'b1, 16'hFF9B, 8'h10);
        wr(1'b1, 16'hFFAF, 8'hC3);
        look("R3 new", 16'hE001, 1'b1, 1'b1);
        chk("R8 bit5", 32'(phys_addr[22:13]), 32'h1C3);

        // R4: task maps differ for same window
        wr(1'b1, 16'hFFA5, 8'h11);
        wr(1'b1, 16'hFFAD, 8'h22);
        look("R4 t0", 16'hA000, 1'b0, 1'b1);
        look("R4 t1", 16'hA000, 1'b1, 1'b1);

        // R6: disabled mode ignores maps
        look("R6", 16'hA777, 1'b1, 1'b0);
        look("R6", 16'h0000, 1'b0, 1'b0);
        look("R6", 16'hFFFF, 1'b1, 1'b0);

        // R7 R8: video offset, bits 7-6 dropped
        wr(1'b1, 16'hFF9B, 8'hCB);
        wr(1'b1, 16'hFF9D, 8'h9E);
        wr(1'b1, 16'hFF9E, 8'h47);
        chk("R7", 32'(vid_offset), 32'hB9E47);
        chk("R8 vbits", 32'(vid_offset[19:16]), 32'hB);
        wr(1'b1, 16'hFFA0, 8'h01);
        look("R8 drop76", 16'h0000, 1'b0, 1'b1);

        // R9: no strobe / foreign address change nothing
        wr(1'b0, 16'hFFA0, 8'hEE);
        wr(1'b0, 16'hFF9E, 8'hEE);
        wr(1'b1, 16'hFFB0, 8'hEE);
        wr(1'b1, 16'hFF9C, 8'hEE);
        look("R9 map", 16'h0000, 1'b0, 1'b1);
        chk("R9 vid", 32'(vid_offset), 32'(exp_vid()));

        // Random mix (R2 R4 R5 R6 R7)
        for (int k = 0; k < 400; k++) begin
            logic [15:0] a;
            case ($urandom % 6)
                0: a = 16'hFF9B;
                1: a = 16'hFF9D;
                2: a = 16'hFF9E;
                3: a = 16'($urandom);
                default: a = {12'hFFA, 4'($urandom)};
            endcase
            wr(1'($urandom % 8 != 0), a, 8'($urandom));
            look("R5 rand", 16'($urandom), 1'($urandom), 1'($urandom % 4 != 0));
            chk("R7 rand", 32'(vid_offset), 32'(exp_vid()));
        end

        // R1: reset again restores identity map
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1; rst_n = 1'b1;
        model_reset();
        look("R1 again", 16'hE000, 1'b1, 1'b1);
        chk("R1 vid again", 32'(vid_offset), 32'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule